// File: doc/BRIEF.md
# Banked Debug Address Comparators

The block holds three 18-bit address comparators, named A, B and C. Each compares the live CPU address bus against a stored match value and drives its own match output. Software reaches the stored values through one shared 8-byte window on a byte-wide peripheral bus. A 2-bit bank-select input decides which comparator's bytes appear in that window. Code 11 maps no comparator at all.

Each comparator's value is split over three window bytes. The high byte (window offset 1) carries address bits 17:16 in its two lowest bits. The mid byte (offset 2) carries bits 15:8, and the low byte (offset 3) carries bits 7:0. An armed input locks the stored values: writes issued while it is high are dropped without effect. Reads are allowed at all times, and read data is combinational from the addressed byte.

Top module: `dbg_addr_cmp_bank`

## Requirements
- R1: After reset every stored comparator bit is zero, so every comparator byte reads 0x00.
- R2: Bank-select code 00 maps comparator A into the window, 01 maps B and 10 maps C. A write strobe with a mapped code updates only the mapped comparator, at the next rising clock edge.
- R3: The high byte at bus address 0x29 stores only write-data bits 1:0 (address bits 17:16), and its bits 7:2 always read as zero. Address 0x2A reads and writes address bits 15:8, and address 0x2B reads and writes address bits 7:0.
- R4: A write issued while the armed input is high changes no stored bit.
- R5: Reads return the mapped comparator's stored bytes whether or not the block is armed.
- R6: With bank-select code 11, reads of the window return 0x00 and writes change no stored bit.
- R7: A comparator's match output is high in the same cycle in which all 18 CPU address bits equal its stored value. A difference in any single bit holds it low.
- R8: A comparator's match output is low whenever its own enable input is low. The enable bits are: bit 0 for A, bit 1 for B, bit 2 for C.
- R9: Read data is 0x00 when the read strobe is low, and also for addresses 0x28 and 0x2C to 0x2F or any address outside 0x28 to 0x2F. Writes to those addresses change no stored bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Peripheral bus byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Combinational read data |
| armed | input | 1 | High blocks all comparator writes |
| bank_sel | input | 2 | Comparator bank mapped into the window |
| cpu_addr | input | 18 | Live CPU address bus |
| cmp_en | input | 3 | Per-comparator match enable |
| cmp_match | output | 3 | Per-comparator match result |

## Verification
Read data and match outputs are combinational, so they are due in the same cycle as their inputs. The bench drives inputs after a falling edge and samples them 1 ns later, before the next rising edge. A write lands at the rising edge that follows its strobe, so its effect is read back only in a later cycle. Random stimulus covers armed and unarmed writes to every offset and bank, and to addresses inside and outside the window. About half of the random CPU addresses are copied from a stored value, some with one bit flipped, so that matches and near-misses both occur.

// File: rtl/dbgcmp_pkg.sv
package dbgcmp_pkg;
    localparam int NCMP   = 3;
    localparam int ADDR_W = 18;
    localparam int HI_W   = ADDR_W - 16;

    localparam logic [2:0] OFF_HI  = 3'd1;
    localparam logic [2:0] OFF_MID = 3'd2;
    localparam logic [2:0] OFF_LO  = 3'd3;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [7:0]      mid;
        logic [7:0]      lo;
    } cmp_regs_t;
endpackage

// File: rtl/dbgcmp_regs.sv
module dbgcmp_regs
    import dbgcmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic [2:0] wr_off,
    input  logic [7:0] wr_data,
    output cmp_regs_t val_q
);
    cmp_regs_t val_d;

    always_comb begin
        val_d = val_q;
        if (wr_en) begin
            case (wr_off)
                OFF_HI:  val_d.hi  = wr_data[HI_W-1:0];
                OFF_MID: val_d.mid = wr_data;
                OFF_LO:  val_d.lo  = wr_data;
                default: val_d = val_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end
endmodule

// File: rtl/dbgcmp_match.sv
module dbgcmp_match
    import dbgcmp_pkg::*;
(
    input  cmp_regs_t [NCMP-1:0] regs,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [NCMP-1:0]      en,
    output logic [NCMP-1:0]      hit
);
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        always_comb hit[i] = en[i] && (cpu_addr == regs[i]);
    end
endmodule

// File: rtl/dbgcmp_rdmux.sv
module dbgcmp_rdmux
    import dbgcmp_pkg::*;
(
    input  cmp_regs_t [NCMP-1:0] regs,
    input  logic                 rd_ok,
    input  logic [1:0]           bank,
    input  logic [2:0]           off,
    output logic [7:0]           rdata
);
    cmp_regs_t sel;

    always_comb begin
        sel   = regs[bank];
        rdata = 8'h00;
        if (rd_ok) begin
            case (off)
                OFF_HI:  rdata = {{(8-HI_W){1'b0}}, sel.hi};
                OFF_MID: rdata = sel.mid;
                OFF_LO:  rdata = sel.lo;
                default: rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/dbg_addr_cmp_bank.sv
module dbg_addr_cmp_bank
    import dbgcmp_pkg::*;
#(
    parameter logic [7:0] WIN_BASE = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              armed,
    input  logic [1:0]        bank_sel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [NCMP-1:0]   cmp_en,
    output logic [NCMP-1:0]   cmp_match
);
    cmp_regs_t [NCMP-1:0]   regs;
    logic [NCMP*ADDR_W-1:0] stored_flat;
    logic                   in_win;
    logic                   bank_ok;
    logic [2:0]             off;
    logic [NCMP-1:0]        wr_en;

    always_comb begin
        in_win  = (bus_addr[7:3] == WIN_BASE[7:3]);
        off     = bus_addr[2:0];
        bank_ok = (int'(bank_sel) < NCMP);
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_bank
        assign wr_en[i] = bus_wr && in_win && !armed && (bank_sel == 2'(i));
        assign stored_flat[i*ADDR_W +: ADDR_W] = regs[i];

        dbgcmp_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[i]),
            .wr_off  (off),
            .wr_data (bus_wdata),
            .val_q   (regs[i])
        );
    end

    dbgcmp_rdmux u_rdmux (
        .regs  (regs),
        .rd_ok (bus_rd && in_win && bank_ok),
        .bank  (bank_sel),
        .off   (off),
        .rdata (bus_rdata)
    );

    dbgcmp_match u_match (
        .regs     (regs),
        .cpu_addr (cpu_addr),
        .en       (cmp_en),
        .hit      (cmp_match)
    );
endmodule

// File: rtl/dbgcmp_chk.sv
module dbgcmp_chk
    import dbgcmp_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [7:0]             bus_addr,
    input logic                   bus_rd,
    input logic [7:0]             bus_rdata,
    input logic                   armed,
    input logic [1:0]             bank_sel,
    input logic [ADDR_W-1:0]      cpu_addr,
    input logic [NCMP-1:0]        cmp_en,
    input logic [NCMP-1:0]        cmp_match,
    input logic [NCMP*ADDR_W-1:0] stored_flat
);
    p_armed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> $stable(stored_flat));

    p_none_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel == 2'b11) |=> $stable(stored_flat));

    p_none_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel == 2'b11) |-> (bus_rdata == 8'h00));

    p_hi_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h29) |-> (bus_rdata[7:2] == 6'd0));

    p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00));

    p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_match & ~cmp_en) == '0);

    for (genvar i = 0; i < NCMP; i++) begin : g_m
        p_match_eq_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_match[i] |-> (cpu_addr == stored_flat[i*ADDR_W +: ADDR_W]));
    end
endmodule

bind dbg_addr_cmp_bank dbgcmp_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .armed       (armed),
    .bank_sel    (bank_sel),
    .cpu_addr    (cpu_addr),
    .cmp_en      (cmp_en),
    .cmp_match   (cmp_match),
    .stored_flat (stored_flat)
);

// File: tb/dbg_addr_cmp_bank_bench.sv
module dbg_addr_cmp_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        armed = 1'b0;
    logic [1:0]  bank_sel = '0;
    logic [17:0] cpu_addr = '0;
    logic [2:0]  cmp_en = '0;
    logic [2:0]  cmp_match;

    int n_chk = 0;
    int n_fail = 0;
    logic [17:0] mdl [3];

    always #5 clk = ~clk;

    dbg_addr_cmp_bank u_dbg_addr_cmp_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .armed(armed),
        .bank_sel(bank_sel), .cpu_addr(cpu_addr), .cmp_en(cmp_en), .cmp_match(cmp_match)
    );

    function automatic logic [7:0] exp_rd(logic [7:0] a, logic [1:0] b, logic rd);
        if (!rd || b == 2'b11 || a[7:3] != 5'b00101) return 8'h00;
        case (a[2:0])
            3'd1: return {6'd0, mdl[b][17:16]};
            3'd2: return mdl[b][15:8];
            3'd3: return mdl[b][7:0];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [2:0] exp_match(logic [17:0] ca, logic [2:0] en);
        logic [2:0] r;
        for (int i = 0; i < 3; i++) r[i] = en[i] && (ca == mdl[i]);
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(logic [7:0] a, logic [7:0] d, logic [1:0] b, logic arm);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bank_sel = b; armed = arm; bus_wr = 1'b1; bus_rd = 1'b0;
        @(posedge clk);
        if (!arm && b != 2'b11 && a[7:3] == 5'b00101) begin
            case (a[2:0])
                3'd1: mdl[b][17:16] = d[1:0];
                3'd2: mdl[b][15:8]  = d;
                3'd3: mdl[b][7:0]   = d;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0; armed = 1'b0;
    endtask

    task automatic do_rd(string req, logic [7:0] a, logic [1:0] b, logic rd, logic arm);
        @(negedge clk);
        bus_addr = a; bank_sel = b; bus_rd = rd; armed = arm;
        #1;
        check(req, bus_rdata, exp_rd(a, b, rd));
        bus_rd = 1'b0; armed = 1'b0;
    endtask

    task automatic do_match(string req, logic [17:0] ca, logic [2:0] en);
        @(negedge clk);
        cpu_addr = ca; cmp_en = en;
        #1;
        check(req, cmp_match, exp_match(ca, en));
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 3; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        for (int b = 0; b < 3; b++)
            for (int o = 1; o < 4; o++) do_rd("R1", 8'h28 + 8'(o), 2'(b), 1'b1, 1'b0);
        do_match("R1", 18'h0, 3'b111);

        // R2 / R3: directed writes to each bank
        do_wr(8'h29, 8'hFF, 2'b00, 1'b0);
        do_wr(8'h2A, 8'hA5, 2'b00, 1'b0);
        do_wr(8'h2B, 8'h3C, 2'b00, 1'b0);
        do_wr(8'h2A, 8'h11, 2'b01, 1'b0);
        do_wr(8'h29, 8'h02, 2'b10, 1'b0);
        do_rd("R3", 8'h29, 2'b00, 1'b1, 1'b0);
        do_rd("R2", 8'h2A, 2'b00, 1'b1, 1'b0);
        do_rd("R2", 8'h2A, 2'b01, 1'b1, 1'b0);
        do_rd("R2", 8'h29, 2'b10, 1'b1, 1'b0);
        do_rd("R2", 8'h2B, 2'b01, 1'b1, 1'b0);

        // R4 / R5: armed lock, armed reads
        do_wr(8'h2A, 8'h77, 2'b00, 1'b1);
        do_rd("R4", 8'h2A, 2'b00, 1'b1, 1'b0);
        do_rd("R5", 8'h2B, 2'b00, 1'b1, 1'b1);

        // R6: bank code 11
        do_wr(8'h2B, 8'h99, 2'b11, 1'b0);
        do_rd("R6", 8'h2B, 2'b11, 1'b1, 1'b0);
        for (int b = 0; b < 3; b++) do_rd("R6", 8'h2B, 2'(b), 1'b1, 1'b0);

        // R9: unmapped offsets and no strobe
        do_wr(8'h28, 8'h55, 2'b00, 1'b0);
        do_wr(8'h2C, 8'h55, 2'b00, 1'b0);
        do_wr(8'h31, 8'h55, 2'b00, 1'b0);
        do_rd("R9", 8'h28, 2'b00, 1'b1, 1'b0);
        do_rd("R9", 8'h2F, 2'b00, 1'b1, 1'b0);
        do_rd("R9", 8'h2A, 2'b00, 1'b0, 1'b0);
        for (int o = 1; o < 4; o++) do_rd("R9", 8'h28 + 8'(o), 2'b00, 1'b1, 1'b0);

        // R7 / R8: exact match, single-bit miss, enable gating
        do_match("R7", mdl[0], 3'b001);
        do_match("R7", mdl[0] ^ 18'h10000, 3'b001);
        do_match("R7", mdl[0] ^ 18'h00001, 3'b111);
        do_match("R8", mdl[0], 3'b110);
        do_match("R8", mdl[1], 3'b000);

        // Random mix
        for (int k = 0; k < 600; k++) begin
            int unsigned r = $urandom % 4;
            logic [7:0] a = (($urandom % 4) == 0) ? 8'($urandom) : 8'h28 + 8'($urandom % 8);
            logic [1:0] b = 2'($urandom);
            if (r == 0) do_wr(a, 8'($urandom), b, ($urandom % 3) == 0);
            else if (r == 1) do_rd(b == 2'b11 ? "R6" : "R5", a, b, ($urandom % 5) != 0, 1'($urandom));
            else begin
                logic [17:0] ca = 18'($urandom);
                int unsigned s = $urandom % 3;
                if (($urandom % 2) == 0) ca = mdl[s];
                if (($urandom % 4) == 0) ca = ca ^ (18'd1 << ($urandom % 18));
                do_match("R7", ca, 3'($urandom));
            end
        end
        finish_up();
    end
endmodule